// File: doc/BRIEF.md
# Multi-Alarm Clock with Hourly Chime

This block keeps the time of day to the second, together with a calendar date and the day of the week, from a one-pulse-per-second tick. Six daily alarms, each with its own hour and minute, are compared against the running time. A three-way hourly signal can be set to gong, cuckoo or silent. When an alarm comes due, or an hour begins, the block raises an event for a downstream announcer. The event carries a code that says what to announce and how many times to announce it.

Software or a keypad controller loads the time, the date and the alarm times through strobed load ports. The per-alarm enable bits are inputs that are sampled when a match occurs. The hourly mode has a single button, and each press advances the mode and requests a preview of the newly chosen sound. Events that arise together wait in a small pending set and are handed out one at a time over a valid/ready pair in a fixed priority order. Sound generation, the display and date arithmetic are left to other blocks.

Top module: `alarm_chime_keeper`

## Requirements
- R1: After reset the time reads 00:00:00, the date reads 1901-01-01, the weekday reads 2 (Tuesday), the hourly mode reads 0 (gong) and no event is valid.
- R2: Each tick advances the seconds, which carry into minutes and hours. Passing 23:59:59 moves the date to the next day and advances the weekday by one, where 0 is Sunday and 6 is Saturday, wrapping 6 to 0.
- R3: Months have their Gregorian lengths. February has 29 days exactly in years divisible by 4.
- R4: The date after 2099-12-31 is 1901-01-01 with weekday Tuesday. A date load is ignored when the year lies outside 1901..2099, the month lies outside 1..12, or the day is 0 or past the end of the month.
- R5: A valid date load sets the weekday to the correct day of the week for that date.
- R6: A time load with hour ≤ 23, minute ≤ 59 and second ≤ 59 takes effect on the next clock and overrides a tick in the same cycle. Any other time load is ignored. A time load never raises an event.
- R7: Alarm k raises one event when a tick moves the time onto its set hh:mm:00 while its enable bit alm_en[k-1] is 1. The alarm raises no event when that bit is 0, and it raises no event at any other second.
- R8: Alarm k presents code k. Alarm 1 presents a repeat count of 2, alarm 6 a count of 4, and alarms 2 to 5 a count of 1.
- R9: The hourly mode is reset to 0 (gong). Each chime_btn pulse steps the mode 0 → 1 (cuckoo) → 2 (silent) → 0, and it queues a preview event with repeat count 1. The preview code is 7 for gong, 8 for cuckoo or 9 for silent, following the mode when the preview is presented.
- R10: When a tick reaches mm:ss = 00:00, an hourly event with repeat count 1 is raised. Its code is 7 in gong mode or 8 in cuckoo mode, and no event is raised in silent mode.
- R11: Pending events are presented one at a time: alarms 1 to 6 in order, then the hourly event, then the preview. While ev_valid is high and ev_ready is low, ev_valid, ev_code and ev_reps hold steady.
- R12: An alarm load with alm_idx 0..5 sets the time of alarm alm_idx+1. The load is ignored if the index is 6 or 7, the hour is above 23, or the minute is above 59.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| time_load | input | 1 | Load strobe for the time |
| time_hh | input | 5 | Hour to load |
| time_mm | input | 6 | Minute to load |
| time_ss | input | 6 | Second to load |
| date_load | input | 1 | Load strobe for the date |
| date_yr | input | 12 | Year to load |
| date_mo | input | 4 | Month to load, 1..12 |
| date_dd | input | 5 | Day to load, 1..31 |
| alm_load | input | 1 | Load strobe for one alarm time |
| alm_idx | input | 3 | Alarm index, 0..5 |
| alm_hh | input | 5 | Alarm hour |
| alm_mm | input | 6 | Alarm minute |
| alm_en | input | 6 | Per-alarm enable bits |
| chime_btn | input | 1 | One-cycle press of the hourly mode button |
| ev_ready | input | 1 | Announcer accepts the presented event |
| ev_valid | output | 1 | An event is presented |
| ev_code | output | 4 | Event code |
| ev_reps | output | 3 | Repeat count |
| cur_hh | output | 5 | Current hour |
| cur_mm | output | 6 | Current minute |
| cur_ss | output | 6 | Current second |
| cur_yr | output | 12 | Current year |
| cur_mo | output | 4 | Current month |
| cur_dd | output | 5 | Current day |
| cur_dow | output | 3 | Current weekday, 0 = Sunday |
| chime_mode | output | 2 | Hourly mode: 0 gong, 1 cuckoo, 2 silent |

## Verification
The bench builds the block with its default parameters: six alarms and a year span of 1901 to 2099 with Tuesday as the first weekday. With these values both ends of the calendar can be reached by loading a date near them, which brings the 2099-to-1901 wrap, the leap and non-leap Februaries and the turn of the century into a few ticks each. The six alarms cover the full priority chain, including the two non-unit repeat counts, and also a collision of all six alarms with the hourly event.

// File: rtl/akc_pkg.sv
package akc_pkg;

  localparam int HH_W   = 5;
  localparam int MM_W   = 6;
  localparam int MO_W   = 4;
  localparam int DD_W   = 5;
  localparam int DOW_W  = 3;
  localparam int REPS_W = 3;

  typedef enum logic [1:0] {
    CH_GONG   = 2'd0,
    CH_CUCKOO = 2'd1,
    CH_OFF    = 2'd2
  } chime_mode_t;

  // Leap rule valid inside the supported two-century span.
  function automatic logic is_leap(input int yr);
    return (yr % 4) == 0;
  endfunction

  function automatic int month_days(input int yr, input int mo);
    case (mo)
      2:           return is_leap(yr) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default:     return 31;
    endcase
  endfunction

  // Days elapsed from 1 January of base_yr to the given date.
  function automatic int days_since(input int base_yr, input int yr,
                                    input int mo, input int dd);
    int n;
    n = (yr - base_yr) * 365 + ((yr - 1) / 4 - (base_yr - 1) / 4);
    for (int m = 1; m < 12; m++) begin
      if (m < mo) n = n + month_days(yr, m);
    end
    n = n + dd - 1;
    return n;
  endfunction

  function automatic logic [DOW_W-1:0] weekday(input int base_yr, input int base_dow,
                                               input int yr, input int mo, input int dd);
    return DOW_W'((days_since(base_yr, yr, mo, dd) + base_dow) % 7);
  endfunction

  function automatic logic [REPS_W-1:0] alarm_reps(input int idx, input int n_alm);
    if (idx == 0)         return REPS_W'(2);
    else if (idx == n_alm - 1) return REPS_W'(4);
    else                  return REPS_W'(1);
  endfunction

endpackage

// File: rtl/akc_timekeeper.sv
module akc_timekeeper
  import akc_pkg::*;
#(
  parameter int YR_W     = 12,
  parameter int YEAR_MIN = 1901,
  parameter int YEAR_MAX = 2099,
  parameter int BASE_DOW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              time_load,
  input  logic [HH_W-1:0]   ld_hh,
  input  logic [MM_W-1:0]   ld_mm,
  input  logic [MM_W-1:0]   ld_ss,
  input  logic              date_load,
  input  logic [YR_W-1:0]   ld_yr,
  input  logic [MO_W-1:0]   ld_mo,
  input  logic [DD_W-1:0]   ld_dd,
  output logic [HH_W-1:0]   cur_hh,
  output logic [MM_W-1:0]   cur_mm,
  output logic [MM_W-1:0]   cur_ss,
  output logic [YR_W-1:0]   cur_yr,
  output logic [MO_W-1:0]   cur_mo,
  output logic [DD_W-1:0]   cur_dd,
  output logic [DOW_W-1:0]  cur_dow,
  output logic [HH_W-1:0]   nxt_hh,
  output logic [MM_W-1:0]   nxt_mm,
  output logic [MM_W-1:0]   nxt_ss,
  output logic              adv,
  output logic              day_roll
);

  logic time_ok, date_ok, carry_m, carry_h, last_day, span_wrap;
  int   dim_cur, dim_ld;

  always_comb begin
    time_ok = (ld_hh < HH_W'(24)) && (ld_mm < MM_W'(60)) && (ld_ss < MM_W'(60));
    dim_ld  = month_days(int'(ld_yr), int'(ld_mo));
    date_ok = (int'(ld_yr) >= YEAR_MIN) && (int'(ld_yr) <= YEAR_MAX) &&
              (ld_mo >= MO_W'(1)) && (ld_mo <= MO_W'(12)) &&
              (ld_dd != '0) && (int'(ld_dd) <= dim_ld);
  end

  always_comb begin
    carry_m = (cur_ss == MM_W'(59));
    carry_h = carry_m && (cur_mm == MM_W'(59));
    nxt_ss  = carry_m ? '0 : cur_ss + MM_W'(1);
    nxt_mm  = carry_m ? ((cur_mm == MM_W'(59)) ? '0 : cur_mm + MM_W'(1)) : cur_mm;
    nxt_hh  = carry_h ? ((cur_hh == HH_W'(23)) ? '0 : cur_hh + HH_W'(1)) : cur_hh;
    adv      = tick && !(time_load && time_ok);
    day_roll = adv && carry_h && (cur_hh == HH_W'(23));
  end

  always_comb begin
    dim_cur   = month_days(int'(cur_yr), int'(cur_mo));
    last_day  = (int'(cur_dd) == dim_cur);
    span_wrap = last_day && (cur_mo == MO_W'(12)) && (cur_yr == YR_W'(YEAR_MAX));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_hh <= '0;
      cur_mm <= '0;
      cur_ss <= '0;
    end else if (time_load && time_ok) begin
      cur_hh <= ld_hh;
      cur_mm <= ld_mm;
      cur_ss <= ld_ss;
    end else if (tick) begin
      cur_hh <= nxt_hh;
      cur_mm <= nxt_mm;
      cur_ss <= nxt_ss;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_yr  <= YR_W'(YEAR_MIN);
      cur_mo  <= MO_W'(1);
      cur_dd  <= DD_W'(1);
      cur_dow <= DOW_W'(BASE_DOW);
    end else if (date_load && date_ok) begin
      cur_yr  <= ld_yr;
      cur_mo  <= ld_mo;
      cur_dd  <= ld_dd;
      cur_dow <= weekday(YEAR_MIN, BASE_DOW, int'(ld_yr), int'(ld_mo), int'(ld_dd));
    end else if (day_roll) begin
      if (span_wrap) begin
        cur_yr  <= YR_W'(YEAR_MIN);
        cur_mo  <= MO_W'(1);
        cur_dd  <= DD_W'(1);
        cur_dow <= DOW_W'(BASE_DOW);
      end else begin
        cur_dow <= (cur_dow == DOW_W'(6)) ? '0 : cur_dow + DOW_W'(1);
        if (last_day) begin
          cur_dd <= DD_W'(1);
          if (cur_mo == MO_W'(12)) begin
            cur_mo <= MO_W'(1);
            cur_yr <= cur_yr + YR_W'(1);
          end else begin
            cur_mo <= cur_mo + MO_W'(1);
          end
        end else begin
          cur_dd <= cur_dd + DD_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/akc_alarm_bank.sv
module akc_alarm_bank
  import akc_pkg::*;
#(
  parameter int NUM_ALM = 6,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alm_load,
  input  logic [IDX_W-1:0]   alm_idx,
  input  logic [HH_W-1:0]    alm_hh,
  input  logic [MM_W-1:0]    alm_mm,
  input  logic [NUM_ALM-1:0] alm_en,
  input  logic               adv,
  input  logic [HH_W-1:0]    nxt_hh,
  input  logic [MM_W-1:0]    nxt_mm,
  input  logic [MM_W-1:0]    nxt_ss,
  output logic [NUM_ALM-1:0] hit
);

  logic set_ok;
  assign set_ok = alm_load && (alm_hh < HH_W'(24)) && (alm_mm < MM_W'(60));

  for (genvar g = 0; g < NUM_ALM; g++) begin : g_alarm
    logic [HH_W-1:0] set_hh;
    logic [MM_W-1:0] set_mm;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        set_hh <= '0;
        set_mm <= '0;
      end else if (set_ok && (alm_idx == IDX_W'(g))) begin
        set_hh <= alm_hh;
        set_mm <= alm_mm;
      end
    end

    assign hit[g] = adv && alm_en[g] && (nxt_ss == '0) &&
                    (nxt_mm == set_mm) && (nxt_hh == set_hh);
  end

endmodule

// File: rtl/akc_event_queue.sv
module akc_event_queue
  import akc_pkg::*;
#(
  parameter int NUM_ALM = 6,
  parameter int CODE_W  = 4,
  parameter int NUM_EVT = NUM_ALM + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] new_evt,
  input  logic [CODE_W-1:0]  chime_code,
  input  logic [CODE_W-1:0]  preview_code,
  input  logic               ev_ready,
  output logic               ev_valid,
  output logic [CODE_W-1:0]  ev_code,
  output logic [REPS_W-1:0]  ev_reps
);

  logic [NUM_EVT-1:0] pend, take;
  logic               found;
  int                 sel_idx;
  logic [CODE_W-1:0]  sel_code;
  logic [REPS_W-1:0]  sel_reps;

  // Lowest index wins: alarms in order, then the hourly event, then the preview.
  always_comb begin
    found   = 1'b0;
    sel_idx = 0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found   = 1'b1;
        sel_idx = i;
      end
    end
    take = '0;
    if (found) take[sel_idx] = 1'b1;
    if (sel_idx < NUM_ALM) begin
      sel_code = CODE_W'(sel_idx + 1);
      sel_reps = alarm_reps(sel_idx, NUM_ALM);
    end else if (sel_idx == NUM_ALM) begin
      sel_code = chime_code;
      sel_reps = REPS_W'(1);
    end else begin
      sel_code = preview_code;
      sel_reps = REPS_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      ev_valid <= 1'b0;
      ev_code  <= '0;
      ev_reps  <= '0;
    end else if (!ev_valid || ev_ready) begin
      pend     <= (pend & ~take) | new_evt;
      ev_valid <= found;
      if (found) begin
        ev_code <= sel_code;
        ev_reps <= sel_reps;
      end
    end else begin
      pend <= pend | new_evt;
    end
  end

endmodule

// File: rtl/alarm_chime_keeper.sv
module alarm_chime_keeper
  import akc_pkg::*;
#(
  parameter int NUM_ALM  = 6,
  parameter int YR_W     = 12,
  parameter int YEAR_MIN = 1901,
  parameter int YEAR_MAX = 2099,
  parameter int BASE_DOW = 2,
  localparam int IDX_W   = $clog2(NUM_ALM + 1),
  localparam int CODE_W  = $clog2(NUM_ALM + 4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_1hz,
  input  logic               time_load,
  input  logic [HH_W-1:0]    time_hh,
  input  logic [MM_W-1:0]    time_mm,
  input  logic [MM_W-1:0]    time_ss,
  input  logic               date_load,
  input  logic [YR_W-1:0]    date_yr,
  input  logic [MO_W-1:0]    date_mo,
  input  logic [DD_W-1:0]    date_dd,
  input  logic               alm_load,
  input  logic [IDX_W-1:0]   alm_idx,
  input  logic [HH_W-1:0]    alm_hh,
  input  logic [MM_W-1:0]    alm_mm,
  input  logic [NUM_ALM-1:0] alm_en,
  input  logic               chime_btn,
  input  logic               ev_ready,
  output logic               ev_valid,
  output logic [CODE_W-1:0]  ev_code,
  output logic [REPS_W-1:0]  ev_reps,
  output logic [HH_W-1:0]    cur_hh,
  output logic [MM_W-1:0]    cur_mm,
  output logic [MM_W-1:0]    cur_ss,
  output logic [YR_W-1:0]    cur_yr,
  output logic [MO_W-1:0]    cur_mo,
  output logic [DD_W-1:0]    cur_dd,
  output logic [DOW_W-1:0]   cur_dow,
  output logic [1:0]         chime_mode
);

  localparam logic [CODE_W-1:0] C_GONG   = CODE_W'(NUM_ALM + 1);
  localparam logic [CODE_W-1:0] C_CUCKOO = CODE_W'(NUM_ALM + 2);
  localparam logic [CODE_W-1:0] C_SILENT = CODE_W'(NUM_ALM + 3);

  logic [HH_W-1:0]    nxt_hh;
  logic [MM_W-1:0]    nxt_mm, nxt_ss;
  logic               adv, day_roll;
  logic [NUM_ALM-1:0] alarm_hit;
  logic               chime_hit;
  chime_mode_t        mode_q;
  logic [CODE_W-1:0]  chime_code, preview_code;

  akc_timekeeper #(
    .YR_W(YR_W), .YEAR_MIN(YEAR_MIN), .YEAR_MAX(YEAR_MAX), .BASE_DOW(BASE_DOW)
  ) u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz),
    .time_load(time_load), .ld_hh(time_hh), .ld_mm(time_mm), .ld_ss(time_ss),
    .date_load(date_load), .ld_yr(date_yr), .ld_mo(date_mo), .ld_dd(date_dd),
    .cur_hh(cur_hh), .cur_mm(cur_mm), .cur_ss(cur_ss),
    .cur_yr(cur_yr), .cur_mo(cur_mo), .cur_dd(cur_dd), .cur_dow(cur_dow),
    .nxt_hh(nxt_hh), .nxt_mm(nxt_mm), .nxt_ss(nxt_ss),
    .adv(adv), .day_roll(day_roll)
  );

  akc_alarm_bank #(.NUM_ALM(NUM_ALM), .IDX_W(IDX_W)) u_alarms (
    .clk(clk), .rst_n(rst_n), .alm_load(alm_load), .alm_idx(alm_idx),
    .alm_hh(alm_hh), .alm_mm(alm_mm), .alm_en(alm_en), .adv(adv),
    .nxt_hh(nxt_hh), .nxt_mm(nxt_mm), .nxt_ss(nxt_ss), .hit(alarm_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= CH_GONG;
    else if (chime_btn) begin
      case (mode_q)
        CH_GONG:   mode_q <= CH_CUCKOO;
        CH_CUCKOO: mode_q <= CH_OFF;
        default:   mode_q <= CH_GONG;
      endcase
    end
  end

  assign chime_mode   = mode_q;
  assign chime_hit    = adv && (nxt_mm == '0) && (nxt_ss == '0) && (mode_q != CH_OFF);
  assign chime_code   = (mode_q == CH_CUCKOO) ? C_CUCKOO : C_GONG;
  assign preview_code = (mode_q == CH_CUCKOO) ? C_CUCKOO :
                        (mode_q == CH_OFF)    ? C_SILENT : C_GONG;

  akc_event_queue #(.NUM_ALM(NUM_ALM), .CODE_W(CODE_W)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .new_evt({chime_btn, chime_hit, alarm_hit}),
    .chime_code(chime_code), .preview_code(preview_code),
    .ev_ready(ev_ready), .ev_valid(ev_valid), .ev_code(ev_code), .ev_reps(ev_reps)
  );

endmodule

// File: rtl/akc_checker.sv
module akc_checker
  import akc_pkg::*;
#(
  parameter int NUM_ALM  = 6,
  parameter int YR_W     = 12,
  parameter int YEAR_MIN = 1901,
  parameter int YEAR_MAX = 2099,
  parameter int CODE_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               date_load,
  input logic               ev_valid,
  input logic               ev_ready,
  input logic [CODE_W-1:0]  ev_code,
  input logic [REPS_W-1:0]  ev_reps,
  input logic [HH_W-1:0]    cur_hh,
  input logic [MM_W-1:0]    cur_mm,
  input logic [MM_W-1:0]    cur_ss,
  input logic [YR_W-1:0]    cur_yr,
  input logic [DD_W-1:0]    cur_dd,
  input logic [DOW_W-1:0]   cur_dow,
  input logic [1:0]         chime_mode,
  input logic [NUM_ALM-1:0] alarm_hit,
  input logic               chime_hit
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_EV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_code) && $stable(ev_reps)); // R11

  AST_CLOCK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cur_ss < MM_W'(60) && cur_mm < MM_W'(60) && cur_hh < HH_W'(24)); // R2

  AST_YEAR_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_yr) >= YEAR_MIN && int'(cur_yr) <= YEAR_MAX); // R4

  AST_FIRST_REPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_code == CODE_W'(1) |-> ev_reps == REPS_W'(2)); // R8

  AST_LAST_REPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_code == CODE_W'(NUM_ALM) |-> ev_reps == REPS_W'(4)); // R8

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ev_code != '0 && ev_code <= CODE_W'(NUM_ALM + 3)); // R8

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    chime_mode != 2'd3); // R9

  AST_ALARM_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    |alarm_hit |=> cur_ss == '0); // R7

  AST_CHIME_ON_HOUR: assert property (@(posedge clk) disable iff (!rst_n)
    chime_hit |=> cur_ss == '0 && cur_mm == '0 && chime_mode != 2'd2); // R10

  AST_DOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(date_load) && cur_dd != $past(cur_dd) &&
    !($past(cur_yr) == YR_W'(YEAR_MAX) && cur_yr != $past(cur_yr))
    |-> cur_dow == (($past(cur_dow) == DOW_W'(6)) ? '0 : $past(cur_dow) + DOW_W'(1))); // R2

endmodule

bind alarm_chime_keeper akc_checker #(
  .NUM_ALM(NUM_ALM), .YR_W(YR_W), .YEAR_MIN(YEAR_MIN), .YEAR_MAX(YEAR_MAX), .CODE_W(CODE_W)
) u_akc_checker (
  .clk(clk), .rst_n(rst_n), .date_load(date_load),
  .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_code(ev_code), .ev_reps(ev_reps),
  .cur_hh(cur_hh), .cur_mm(cur_mm), .cur_ss(cur_ss), .cur_yr(cur_yr),
  .cur_dd(cur_dd), .cur_dow(cur_dow), .chime_mode(chime_mode),
  .alarm_hit(alarm_hit), .chime_hit(chime_hit)
);

// File: tb/test_alarm_chime_keeper.sv
module test_alarm_chime_keeper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        time_load = 1'b0;
  logic [4:0]  time_hh = '0;
  logic [5:0]  time_mm = '0, time_ss = '0;
  logic        date_load = 1'b0;
  logic [11:0] date_yr = '0;
  logic [3:0]  date_mo = '0;
  logic [4:0]  date_dd = '0;
  logic        alm_load = 1'b0;
  logic [2:0]  alm_idx = '0;
  logic [4:0]  alm_hh = '0;
  logic [5:0]  alm_mm = '0;
  logic [5:0]  alm_en = '0;
  logic        chime_btn = 1'b0;
  logic        ev_ready = 1'b0;
  logic        ev_valid;
  logic [3:0]  ev_code;
  logic [2:0]  ev_reps;
  logic [4:0]  cur_hh, cur_dd;
  logic [5:0]  cur_mm, cur_ss;
  logic [11:0] cur_yr;
  logic [3:0]  cur_mo;
  logic [2:0]  cur_dow;
  logic [1:0]  chime_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alarm_chime_keeper i_alarm_chime_keeper (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
    .time_load(time_load), .time_hh(time_hh), .time_mm(time_mm), .time_ss(time_ss),
    .date_load(date_load), .date_yr(date_yr), .date_mo(date_mo), .date_dd(date_dd),
    .alm_load(alm_load), .alm_idx(alm_idx), .alm_hh(alm_hh), .alm_mm(alm_mm),
    .alm_en(alm_en), .chime_btn(chime_btn), .ev_ready(ev_ready),
    .ev_valid(ev_valid), .ev_code(ev_code), .ev_reps(ev_reps),
    .cur_hh(cur_hh), .cur_mm(cur_mm), .cur_ss(cur_ss), .cur_yr(cur_yr),
    .cur_mo(cur_mo), .cur_dd(cur_dd), .cur_dow(cur_dow), .chime_mode(chime_mode)
  );

  // Weekday by a table-driven formula, 0 = Sunday.
  function automatic int ref_dow(input int y, input int m, input int d);
    int t[12] = '{0, 3, 2, 5, 0, 3, 5, 1, 4, 6, 2, 4};
    if (m < 3) y = y - 1;
    return (y + y / 4 - y / 100 + y / 400 + t[m-1] + d) % 7;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick_1hz = 1'b1;
    @(negedge clk) tick_1hz = 1'b0;
  endtask

  task automatic set_time(input int h, input int m, input int s);
    @(negedge clk);
    time_load = 1'b1; time_hh = 5'(h); time_mm = 6'(m); time_ss = 6'(s);
    @(negedge clk) time_load = 1'b0;
  endtask

  task automatic set_date(input int y, input int m, input int d);
    @(negedge clk);
    date_load = 1'b1; date_yr = 12'(y); date_mo = 4'(m); date_dd = 5'(d);
    @(negedge clk) date_load = 1'b0;
  endtask

  task automatic set_alarm(input int idx, input int h, input int m);
    @(negedge clk);
    alm_load = 1'b1; alm_idx = 3'(idx); alm_hh = 5'(h); alm_mm = 6'(m);
    @(negedge clk) alm_load = 1'b0;
  endtask

  task automatic press_btn();
    @(negedge clk) chime_btn = 1'b1;
    @(negedge clk) chime_btn = 1'b0;
  endtask

  task automatic expect_event(input string req, input int code, input int reps);
    int w = 0;
    while (!ev_valid && w < 8) begin
      @(negedge clk);
      w++;
    end
    check({req, " valid"}, int'(ev_valid), 1);
    check({req, " code"}, int'(ev_code), code);
    check({req, " reps"}, int'(ev_reps), reps);
    ev_ready = 1'b1;
    @(negedge clk) ev_ready = 1'b0;
  endtask

  task automatic expect_none(input string req);
    repeat (4) @(negedge clk);
    check({req, " no event"}, int'(ev_valid), 0);
  endtask

  task automatic check_date(input string req, input int y, input int m, input int d);
    check({req, " year"}, int'(cur_yr), y);
    check({req, " month"}, int'(cur_mo), m);
    check({req, " day"}, int'(cur_dd), d);
    check({req, " weekday"}, int'(cur_dow), ref_dow(y, m, d));
  endtask

  task automatic t_reset();
    check("R1 hh", int'(cur_hh), 0);
    check("R1 mm", int'(cur_mm), 0);
    check("R1 ss", int'(cur_ss), 0);
    check("R1 date year", int'(cur_yr), 1901);
    check("R1 date month", int'(cur_mo), 1);
    check("R1 date day", int'(cur_dd), 1);
    check("R1 weekday", int'(cur_dow), 2);
    check("R1 mode", int'(chime_mode), 0);
    check("R1 valid", int'(ev_valid), 0);
  endtask

  task automatic t_rollover();
    set_date(1999, 12, 31);
    set_time(23, 59, 58);
    do_tick();
    check("R2 second step", int'(cur_ss), 59);
    do_tick();
    check("R2 hour wrap", int'(cur_hh), 0);
    check("R2 minute wrap", int'(cur_mm), 0);
    check("R2 second wrap", int'(cur_ss), 0);
    check_date("R2 new year", 2000, 1, 1);
    expect_event("R10 gong at midnight", 7, 1);
  endtask

  task automatic roll_from(input int y, input int m, input int d);
    set_date(y, m, d);
    set_time(23, 59, 59);
    do_tick();
  endtask

  task automatic t_leap();
    roll_from(2000, 2, 28);
    check_date("R3 leap 2000 feb 29", 2000, 2, 29);
    expect_event("R10 hourly", 7, 1);
    roll_from(2000, 2, 29);
    check_date("R3 leap 2000 to march", 2000, 3, 1);
    expect_event("R10 hourly", 7, 1);
    roll_from(2001, 2, 28);
    check_date("R3 common year to march", 2001, 3, 1);
    expect_event("R10 hourly", 7, 1);
    roll_from(2010, 4, 30);
    check_date("R3 thirty day month", 2010, 5, 1);
    expect_event("R10 hourly", 7, 1);
    roll_from(2096, 2, 28);
    check_date("R3 leap 2096", 2096, 2, 29);
    expect_event("R10 hourly", 7, 1);
  endtask

  task automatic t_wrap();
    roll_from(2099, 12, 31);
    check("R4 wrap year", int'(cur_yr), 1901);
    check("R4 wrap month", int'(cur_mo), 1);
    check("R4 wrap day", int'(cur_dd), 1);
    check("R4 wrap weekday", int'(cur_dow), 2);
    expect_event("R10 hourly", 7, 1);
  endtask

  task automatic t_dow_load();
    int ys[6] = '{1901, 1999, 2024, 2099, 1950, 2000};
    int ms[6] = '{1, 12, 2, 12, 7, 3};
    int ds[6] = '{1, 31, 29, 31, 4, 1};
    for (int i = 0; i < 6; i++) begin
      set_date(ys[i], ms[i], ds[i]);
      check_date("R5 load weekday", ys[i], ms[i], ds[i]);
    end
  endtask

  task automatic t_bad_loads();
    set_date(2010, 5, 5);
    set_date(1900, 6, 1);
    check_date("R4 year 1900 ignored", 2010, 5, 5);
    set_date(2100, 1, 1);
    check_date("R4 year 2100 ignored", 2010, 5, 5);
    set_date(2010, 13, 1);
    check_date("R4 month 13 ignored", 2010, 5, 5);
    set_date(2010, 2, 29);
    check_date("R4 feb 29 common ignored", 2010, 5, 5);
    set_date(2010, 4, 31);
    check_date("R4 april 31 ignored", 2010, 5, 5);
    set_date(2010, 6, 0);
    check_date("R4 day 0 ignored", 2010, 5, 5);
    set_time(10, 20, 30);
    check("R6 load hh", int'(cur_hh), 10);
    check("R6 load mm", int'(cur_mm), 20);
    check("R6 load ss", int'(cur_ss), 30);
    set_time(24, 0, 0);
    check("R6 hour 24 ignored", int'(cur_hh), 10);
    set_time(12, 60, 0);
    check("R6 minute 60 ignored", int'(cur_mm), 20);
    set_time(12, 0, 60);
    check("R6 second 60 ignored", int'(cur_ss), 30);
    // Load and tick in the same cycle: load wins.
    @(negedge clk);
    time_load = 1'b1; tick_1hz = 1'b1; time_hh = 5'd3; time_mm = 6'd4; time_ss = 6'd5;
    @(negedge clk);
    time_load = 1'b0; tick_1hz = 1'b0;
    check("R6 load beats tick", int'(cur_ss), 5);
    expect_none("R6 load quiet");
  endtask

  task automatic t_priority();
    for (int i = 0; i < 6; i++) set_alarm(i, 7, 0);
    alm_en = 6'b111111;
    set_time(6, 59, 59);
    do_tick();
    repeat (4) @(negedge clk);
    check("R11 stalled valid", int'(ev_valid), 1);
    check("R11 stalled code", int'(ev_code), 1);
    expect_event("R8 alarm 1", 1, 2);
    expect_event("R8 alarm 2", 2, 1);
    expect_event("R8 alarm 3", 3, 1);
    expect_event("R8 alarm 4", 4, 1);
    expect_event("R8 alarm 5", 5, 1);
    expect_event("R8 alarm 6", 6, 4);
    expect_event("R11 hourly after alarms", 7, 1);
    expect_none("R11 queue empty");
  endtask

  task automatic t_disabled();
    alm_en = 6'b111011;
    set_time(6, 59, 59);
    do_tick();
    expect_event("R7 alarm 1", 1, 2);
    expect_event("R7 alarm 2", 2, 1);
    expect_event("R7 alarm 3 skipped", 4, 1);
    expect_event("R7 alarm 5", 5, 1);
    expect_event("R7 alarm 6", 6, 4);
    expect_event("R7 hourly", 7, 1);
    expect_none("R7 nothing more");
  endtask

  task automatic t_not_zero();
    alm_en = 6'b111111;
    set_time(7, 0, 0);
    expect_none("R6 load onto alarm time");
    do_tick();
    expect_none("R7 second one");
    set_time(7, 0, 30);
    do_tick();
    expect_none("R7 second 31");
  endtask

  task automatic t_alarm_load();
    alm_en = 6'b000010;
    set_alarm(1, 9, 15);
    set_alarm(1, 25, 40);
    set_alarm(1, 9, 61);
    set_alarm(6, 9, 14);
    set_alarm(7, 9, 14);
    set_time(9, 13, 59);
    do_tick();
    expect_none("R12 bad loads no hit");
    set_time(9, 14, 59);
    do_tick();
    expect_event("R12 alarm 2 at 09:15", 2, 1);
    expect_none("R12 single");
  endtask

  task automatic t_chime();
    alm_en = '0;
    press_btn();
    check("R9 mode cuckoo", int'(chime_mode), 1);
    expect_event("R9 preview cuckoo", 8, 1);
    press_btn();
    check("R9 mode silent", int'(chime_mode), 2);
    expect_event("R9 preview silent", 9, 1);
    set_time(7, 59, 59);
    do_tick();
    check("R10 hour reached", int'(cur_hh), 8);
    expect_none("R10 silent hour");
    press_btn();
    check("R9 mode gong", int'(chime_mode), 0);
    expect_event("R9 preview gong", 7, 1);
    press_btn();
    expect_event("R9 preview cuckoo again", 8, 1);
    set_time(8, 59, 59);
    do_tick();
    expect_event("R10 cuckoo hour", 8, 1);
    set_time(9, 30, 59);
    do_tick();
    expect_none("R10 half hour quiet");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rollover();
    t_leap();
    t_wrap();
    t_dow_load();
    t_bad_loads();
    t_priority();
    t_disabled();
    t_not_zero();
    t_alarm_load();
    t_chime();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule